// File: doc/BRIEF.md
# BCD Clock-Calendar Counter

This block keeps wall-clock time and calendar date as packed BCD bytes: seconds, minutes, hours, weekday, day of month, month and a two-digit year. A prescaler counts enable pulses from a 32.768 kHz reference and produces one single-cycle second strobe for every full prescaler wrap. It also produces a switchable 1 Hz square wave. The carry ripples from seconds up through the year. The day-of-month limit follows the length of the month, and February has 29 days in every year whose value is divisible by four.

Software loads a field by presenting an index, a write strobe and a byte. Unused bits in the byte are dropped before they are stored. Writing the seconds field also restarts the prescaler, so the next second is a full second long.

Reads are served from a shadow copy. A read strobe captures all seven live fields into the shadow copy. A burst of reads then sees one consistent moment in time while the live counters keep running. The hours byte carries its own format selector, so 12-hour and 24-hour operation can be mixed by writing that byte.

Top module: `rtc_calendar`

## Requirements
- R1: After reset, the shadow copy and the live fields hold seconds 00, minutes 00, hours 00 in 24-hour format, weekday 1, date 01, month 01 and year 00. Field indices are 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 date, 5 month, 6 year. Index 7 reads 0x00.
- R2: `secPulse` is high for exactly one cycle, in the cycle of every 2^PRESC_W-th `refTick` pulse. `sqOut` equals the prescaler's top bit while `sqEnable` is 1, and is 0 otherwise.
- R3: On a second strobe, seconds count in BCD from 0x59 to 0x00 and carry into minutes. Minutes also count from 0x59 to 0x00 and carry into hours.
- R4: When bit 6 of the hours byte is 0 (24-hour format), hours count 0x00 to 0x23. The step from 0x23 to 0x00 is midnight and advances the weekday and the date.
- R5: When bit 6 of the hours byte is 1 (12-hour format), bit 5 is the PM flag and bits 4:0 hold 01 to 12 in BCD. The step from 11 to 12 toggles bit 5, and the step from 12 goes to 01 without touching bit 5. The step from 11 PM to 12 AM is midnight.
- R6: At midnight the weekday advances, and it goes from 7 back to 1.
- R7: At midnight the date advances. It returns to 01 after 30 in months 04, 06, 09 and 11, after 31 in the other months, and in month 02 after 29 when the year is divisible by 4 and after 28 otherwise.
- R8: When the date wraps, the month advances, and month 0x12 wraps to 0x01 while advancing the year. Year 0x99 wraps to 0x00.
- R9: A write to field 0 clears the prescaler. The next `secPulse` then comes on the 2^PRESC_W-th `refTick` after the write.
- R10: `rdStart` copies all live fields into the shadow copy. `rdData` shows the shadow entry chosen by `rdAddr` and does not follow the live fields until the next `rdStart`.
- R11: Written bytes are masked before they are stored. The masks are 0x7F for seconds, minutes and hours, 0x07 for weekday, 0x3F for date, 0x1F for month and 0xFF for year, so masked bits read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refTick | input | 1 | One-cycle enable at the 32.768 kHz reference rate |
| sqEnable | input | 1 | Enables the 1 Hz square-wave output |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | ADDR_W | Field index for the write |
| wrData | input | 8 | Write byte |
| rdStart | input | 1 | Captures the live fields into the shadow copy |
| rdAddr | input | ADDR_W | Field index for the read |
| rdData | output | 8 | Shadow byte for `rdAddr` |
| secPulse | output | 1 | One-cycle second strobe |
| sqOut | output | 1 | 1 Hz square wave, 50% duty |

## Verification
The assertions take for granted that every byte written is a legal BCD value for its field once masked. This means seconds and minutes stay within 00 to 59, the weekday within 1 to 7 and the month within 01 to 12. They also take for granted that `refTick` and a seconds write never arrive in the same cycle. The stimulus only builds times from valid binary values and converts them to BCD. Its one masking test uses bytes whose masked result is still legal, and `refTick` is never pulsed while a write is under way. Random start times are biased toward 59 seconds, 59 minutes, 23 hours and the last day of a month, so that short runs cross every carry.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NREG = 7;
  localparam int SEC  = 0;
  localparam int MIN  = 1;
  localparam int HOUR = 2;
  localparam int WDAY = 3;
  localparam int DATE = 4;
  localparam int MON  = 5;
  localparam int YEAR = 6;

  typedef struct packed {
    logic            tick;
    logic [NREG-1:0] wrSel;
    logic [7:0]      wrVal;
  } rtcStrobe_t;

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] fieldMask(input int idx);
    case (idx)
      SEC, MIN, HOUR: return 8'h7F;
      WDAY:           return 8'h07;
      DATE:           return 8'h3F;
      MON:            return 8'h1F;
      YEAR:           return 8'hFF;
      default:        return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] resetVal(input int idx);
    case (idx)
      WDAY, DATE, MON: return 8'h01;
      default:         return 8'h00;
    endcase
  endfunction

  // Divisible by four: even tens need ones of 0/4/8, odd tens need 2/6.
  function automatic logic isLeap(input logic [7:0] yr);
    if (yr[4]) return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] lastDate(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return isLeap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int PRESC_W = 15,
  parameter int ADDR_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refTick,
  input  logic              sqEnable,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  output rtcStrobe_t        strobes,
  output logic              sqOut
);
  localparam logic [PRESC_W-1:0] PRESC_LAST = '1;

  logic [PRESC_W-1:0] presc;
  logic [NREG-1:0]    sel;

  for (genvar i = 0; i < NREG; i++) begin : g_dec
    assign sel[i] = wrEn && (wrAddr == ADDR_W'(i));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           presc <= '0;
    else if (sel[SEC])   presc <= '0;
    else if (refTick)    presc <= presc + 1'b1;
  end

  assign strobes.wrSel = sel;
  assign strobes.wrVal = wrData & fieldMask(int'(wrAddr));
  assign strobes.tick  = refTick && (presc == PRESC_LAST) && !sel[SEC];
  assign sqOut         = sqEnable && presc[PRESC_W-1];

  // R2: a second strobe never lasts two cycles
  p_tick_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.tick |=> !strobes.tick);

  // R9: a seconds write restarts the count, so no strobe can follow at once
  p_secwr_restart_r9: assert property (@(posedge clk) disable iff (!rstN)
    sel[SEC] |=> !strobes.tick);
endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  rtcStrobe_t        strobes,
  input  logic              rdStart,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData
);
  localparam int FLAT_W = NREG * 8;

  logic [7:0] live [NREG];
  logic [7:0] snap [NREG];
  logic [7:0] nxt  [NREG];
  logic [FLAT_W-1:0] liveFlat, snapFlat;

  logic secWrap, minWrap, cMin, cHour, cDay, cMon, cYear;
  logic is12, pmNow, midnight;
  logic [4:0] h12;
  logic [7:0] hourAdv;

  always_comb begin
    secWrap = live[SEC] == 8'h59;
    minWrap = live[MIN] == 8'h59;
    cMin    = strobes.tick && secWrap;
    cHour   = cMin && minWrap;

    is12  = live[HOUR][6];
    pmNow = live[HOUR][5];
    h12   = live[HOUR][4:0];
    if (is12) begin
      midnight = (h12 == 5'h11) && pmNow;
      if (h12 == 5'h11)      hourAdv = {2'b01, ~pmNow, 5'h12};
      else if (h12 == 5'h12) hourAdv = {2'b01, pmNow, 5'h01};
      else                   hourAdv = {2'b01, pmNow, 5'(bcdInc({3'b000, h12}))};
    end else begin
      midnight = live[HOUR][5:0] == 6'h23;
      hourAdv  = midnight ? 8'h00 : bcdInc({2'b00, live[HOUR][5:0]});
    end

    cDay  = cHour && midnight;
    cMon  = cDay && (live[DATE] == lastDate(live[MON], live[YEAR]));
    cYear = cMon && (live[MON] == 8'h12);

    nxt[SEC]  = strobes.tick ? (secWrap ? 8'h00 : bcdInc(live[SEC])) : live[SEC];
    nxt[MIN]  = cMin  ? (minWrap ? 8'h00 : bcdInc(live[MIN])) : live[MIN];
    nxt[HOUR] = cHour ? hourAdv : live[HOUR];
    nxt[WDAY] = cDay  ? ((live[WDAY] == 8'h07) ? 8'h01 : live[WDAY] + 8'h01) : live[WDAY];
    nxt[DATE] = cDay  ? (cMon ? 8'h01 : bcdInc(live[DATE])) : live[DATE];
    nxt[MON]  = cMon  ? (cYear ? 8'h01 : bcdInc(live[MON])) : live[MON];
    nxt[YEAR] = cYear ? ((live[YEAR] == 8'h99) ? 8'h00 : bcdInc(live[YEAR])) : live[YEAR];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) begin
        live[i] <= resetVal(i);
        snap[i] <= resetVal(i);
      end
    end else begin
      for (int i = 0; i < NREG; i++) begin
        live[i] <= strobes.wrSel[i] ? strobes.wrVal : nxt[i];
        if (rdStart) snap[i] <= live[i];
      end
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_flat
    assign liveFlat[i*8 +: 8] = live[i];
    assign snapFlat[i*8 +: 8] = snap[i];
  end

  assign rdData = (rdAddr < ADDR_W'(NREG)) ? snap[rdAddr] : 8'h00;

  // R3: seconds stay legal BCD
  p_sec_bcd_r3: assert property (@(posedge clk) disable iff (!rstN)
    (live[SEC][3:0] <= 4'd9) && (live[SEC][7:4] <= 4'd5));

  // R3: the seconds wrap lands on zero
  p_sec_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.tick && (live[SEC] == 8'h59) && !strobes.wrSel[SEC]) |=> (live[SEC] == 8'h00));

  // R3: with no strobe and no write, nothing moves
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.tick && (strobes.wrSel == '0)) |=> $stable(liveFlat));

  // R6: weekday remains within 1..7
  p_wday_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    (live[WDAY] >= 8'h01) && (live[WDAY] <= 8'h07));

  // R8: month remains within 01..12
  p_mon_range_r8: assert property (@(posedge clk) disable iff (!rstN)
    (live[MON] >= 8'h01) && (live[MON] <= 8'h12));

  // R10: the shadow copy is frozen between captures
  p_snap_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !rdStart |=> $stable(snapFlat));
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int PRESC_W = 15,
  parameter int ADDR_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refTick,
  input  logic              sqEnable,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              rdStart,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic              secPulse,
  output logic              sqOut
);
  rtcStrobe_t strobes;

  rtc_ctrl #(.PRESC_W(PRESC_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .refTick(refTick), .sqEnable(sqEnable),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strobes(strobes), .sqOut(sqOut)
  );

  rtc_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .rdStart(rdStart), .rdAddr(rdAddr), .rdData(rdData)
  );

  assign secPulse = strobes.tick;
endmodule

// File: tb/rtc_calendar_test.sv
module rtc_calendar_test;
  localparam int PW  = 3;
  localparam int DIV = 1 << PW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refTick = 1'b0, sqEnable = 1'b0, wrEn = 1'b0, rdStart = 1'b0;
  logic [2:0] wrAddr = '0, rdAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic secPulse, sqOut;

  always #4 clk = ~clk;

  rtc_calendar #(.PRESC_W(PW), .ADDR_W(3)) uut (
    .clk(clk), .rstN(rstN), .refTick(refTick), .sqEnable(sqEnable),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdStart(rdStart), .rdAddr(rdAddr), .rdData(rdData),
    .secPulse(secPulse), .sqOut(sqOut)
  );

  int errors = 0, checks = 0, phase = 0;
  bit lastPulse = 0;
  int mSec, mMin, mH24, mDay, mDate, mMon, mYear;
  bit m12;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] toBcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int daysIn(input int mon, input int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] expReg(input int idx);
    int h;
    case (idx)
      0: return toBcd(mSec);
      1: return toBcd(mMin);
      2: begin
        if (!m12) return toBcd(mH24);
        h = mH24 % 12;
        if (h == 0) h = 12;
        return 8'h40 | ((mH24 >= 12) ? 8'h20 : 8'h00) | toBcd(h);
      end
      3: return toBcd(mDay);
      4: return toBcd(mDate);
      5: return toBcd(mMon);
      6: return toBcd(mYear);
      default: return 8'h00;
    endcase
  endfunction

  task automatic advanceModel();
    mSec++;
    if (mSec < 60) return;
    mSec = 0; mMin++;
    if (mMin < 60) return;
    mMin = 0; mH24++;
    if (mH24 < 24) return;
    mH24 = 0;
    mDay = (mDay == 7) ? 1 : mDay + 1;
    mDate++;
    if (mDate <= daysIn(mMon, mYear)) return;
    mDate = 1; mMon++;
    if (mMon <= 12) return;
    mMon = 1;
    mYear = (mYear + 1) % 100;
  endtask

  task automatic refPulse();
    @(negedge clk);
    refTick = 1'b1;
    phase = (phase + 1) % DIV;
    lastPulse = (phase == 0);
    if (lastPulse) advanceModel();
    #1 chk("R2 secPulse", {7'b0, secPulse}, {7'b0, lastPulse});
    @(negedge clk);
    refTick = 1'b0;
    #1 chk("R2 sqOut", {7'b0, sqOut}, {7'b0, (sqEnable && phase >= DIV / 2)});
  endtask

  task automatic runSeconds(input int n);
    int k = 0;
    while (k < n) begin
      refPulse();
      if (lastPulse) k++;
    end
  endtask

  task automatic writeReg(input int addr, input logic [7:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 3'(addr); wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
    if (addr == 0) phase = 0;
  endtask

  task automatic setTime(input int s, input int m, input int h, input bit use12,
                         input int dy, input int dt, input int mo, input int yr);
    mSec = s; mMin = m; mH24 = h; m12 = use12;
    mDay = dy; mDate = dt; mMon = mo; mYear = yr;
    for (int i = 0; i < 7; i++) writeReg(i, expReg(i));
  endtask

  task automatic capture();
    @(negedge clk);
    rdStart = 1'b1;
    @(negedge clk);
    rdStart = 1'b0;
  endtask

  task automatic checkAll(input string req);
    capture();
    for (int i = 0; i < 7; i++) begin
      rdAddr = 3'(i);
      #1 chk(req, rdData, expReg(i));
    end
  endtask

  initial begin
    logic [7:0] saved [7];
    void'($urandom(32'd1357));

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset values
    mSec = 0; mMin = 0; mH24 = 0; m12 = 0; mDay = 1; mDate = 1; mMon = 1; mYear = 0;
    checkAll("R1 reset");
    rdAddr = 3'd7;
    #1 chk("R1 index7", rdData, 8'h00);

    // R2: prescaler and square wave
    sqEnable = 1'b1;
    runSeconds(2);
    sqEnable = 1'b0;
    runSeconds(1);
    checkAll("R2 count");

    // R3: minute and hour carries
    setTime(59, 59, 0, 0, 2, 10, 3, 21);
    runSeconds(1);
    checkAll("R3 carry");

    // R4 and R6: 24-hour midnight, weekday 7 wraps to 1
    setTime(59, 59, 23, 0, 7, 15, 6, 30);
    runSeconds(1);
    checkAll("R4 R6 midnight");

    // R5: 12-hour sequence
    setTime(59, 59, 11, 1, 3, 5, 5, 5);
    runSeconds(1);
    chk("R5 11AM to 12PM", expReg(2), 8'h72);
    checkAll("R5 noon");
    setTime(59, 59, 12, 1, 3, 5, 5, 5);
    runSeconds(1);
    chk("R5 12PM to 1PM", expReg(2), 8'h61);
    checkAll("R5 one PM");
    setTime(59, 59, 23, 1, 4, 5, 5, 5);
    runSeconds(1);
    chk("R5 11PM to 12AM", expReg(2), 8'h52);
    checkAll("R5 midnight");

    // R7: month lengths
    setTime(59, 59, 23, 0, 1, 28, 2, 24);
    runSeconds(1);
    checkAll("R7 leap Feb28");
    runSeconds(86400 - 86400 + 0);
    setTime(59, 59, 23, 0, 1, 28, 2, 23);
    runSeconds(1);
    checkAll("R7 plain Feb28");
    setTime(59, 59, 23, 0, 1, 29, 2, 0);
    runSeconds(1);
    checkAll("R7 leap year00");
    setTime(59, 59, 23, 0, 1, 30, 4, 11);
    runSeconds(1);
    checkAll("R7 Apr30");
    setTime(59, 59, 23, 0, 1, 30, 1, 11);
    runSeconds(1);
    checkAll("R7 Jan30");

    // R8: year wrap
    setTime(59, 59, 23, 0, 5, 31, 12, 99);
    runSeconds(1);
    checkAll("R8 new century");

    // R9: seconds write restarts the prescaler
    setTime(10, 0, 0, 0, 1, 1, 1, 1);
    repeat (5) refPulse();
    writeReg(0, 8'h20);
    mSec = 20;
    repeat (DIV - 1) refPulse();
    checkAll("R9 no early tick");
    refPulse();
    chk("R9 full second", {7'b0, lastPulse}, 8'h01);
    checkAll("R9 after tick");

    // R10: shadow copy is frozen
    setTime(30, 15, 8, 0, 2, 3, 4, 5);
    capture();
    for (int i = 0; i < 7; i++) saved[i] = expReg(i);
    runSeconds(3);
    for (int i = 0; i < 7; i++) begin
      rdAddr = 3'(i);
      #1 chk("R10 frozen", rdData, saved[i]);
    end
    rdAddr = 3'd7;
    #1 chk("R10 index7", rdData, 8'h00);
    checkAll("R10 recapture");

    // R11: masked bits read back as 0
    writeReg(0, 8'hA5); mSec = 25;
    writeReg(1, 8'hD9); mMin = 59;
    writeReg(2, 8'h93); mH24 = 13; m12 = 0;
    writeReg(3, 8'hFF); mDay = 7;
    writeReg(4, 8'hC5); mDate = 5;
    writeReg(5, 8'hF2); mMon = 12;
    checkAll("R11 masks");

    // Random starts near carries, R3 to R8
    for (int it = 0; it < 40; it++) begin
      int yr, mo, dt, h, m, s;
      yr = $urandom_range(0, 99);
      mo = $urandom_range(1, 12);
      dt = ($urandom_range(0, 1) == 1) ? daysIn(mo, yr) : $urandom_range(1, daysIn(mo, yr));
      h  = ($urandom_range(0, 1) == 1) ? 23 : $urandom_range(0, 23);
      m  = ($urandom_range(0, 2) != 0) ? 59 : $urandom_range(0, 59);
      s  = $urandom_range(40, 59);
      sqEnable = 1'($urandom_range(0, 1));
      setTime(s, m, h, 1'($urandom_range(0, 1)), $urandom_range(1, 7), dt, mo, yr);
      runSeconds($urandom_range(1, 40));
      checkAll("R3-R8 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1500000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule